// File: doc/BRIEF.md
# Compartment Semaphore Bank

A bank of hardware semaphores, one per peripheral, that lets independent execution compartments claim exclusive use of a peripheral. Each entry has a configuration word and a semaphore word, both on a simple memory-mapped register bus. Every bus write carries the 3-bit compartment ID of the initiator. The bank uses that ID to decide whether a lock request is granted and to record which compartment owns the lock. Only that owner can release the lock.

For each entry the bank also drives a combinational allow bit for one query compartment ID. Downstream access filtering can use this bit to decide whether that compartment may reach the peripheral. The bank does not filter peripheral traffic itself.

Top module: `sem_bank`

## Requirements
- R1: After reset, every configuration word and every semaphore word reads 0.
- R2: The configuration word of entry n is at byte offset 0x100+8n and the semaphore word is at 0x104+8n. In the configuration word, bit 0 is the filter enable, bit 1 is the semaphore enable, bits 6:4 are the static compartment ID and bits 23:16 are the whitelist (bit 16+c is compartment c). All other bits read 0, so a write of 0xFFFFFFFF reads back 0x00FF0073.
- R3: An entry is in semaphore mode when bits 0 and 1 of its configuration word are both set. In that mode, a write with bit 0 = 1 to a free semaphore by a compartment whose whitelist bit is set takes the lock. The semaphore word then reads bit 0 = 1 and bits 6:4 = the taker's ID.
- R4: A semaphore write by a compartment that is not on the whitelist leaves the entry free.
- R5: A write with bit 0 = 1 by the current owner releases the lock, and the semaphore word then reads 0.
- R6: A write with bit 0 = 1 to a held semaphore by any compartment other than the owner leaves the owner and the held state unchanged.
- R7: A semaphore write with bit 0 = 0 has no effect. A semaphore write while the entry is not in semaphore mode has no effect.
- R8: A configuration write that clears the filter enable or the semaphore enable frees a held lock in the same cycle the new configuration takes effect.
- R9: allow_o[n] is 1 for query ID q under these conditions. If filtering is off, it is always 1. In semaphore mode, it is 1 only while the entry is held by q, and the static ID is ignored. Otherwise, it is 1 when the static ID is 0 or equals q.
- R10: rdata_o presents the addressed word one cycle after a read request. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| cid_i | input | 3 | Compartment ID of the initiator |
| rdata_o | output | 32 | Read data, registered |
| chk_cid_i | input | 3 | Compartment ID queried by allow_o |
| allow_o | output | N_ENTRY | Per-entry access allow for chk_cid_i |

## Verification
The bench sweeps every entry against every compartment ID, with a whitelist pattern that differs per entry. A design that ignores the whitelist would grant locks that should be refused, and one that records the wrong ID would show it in bits 6:4. With each lock held, the bench tries a release by an intruding compartment and a write with bit 0 = 0. A design that toggles on any write would drop the lock in those cases. The bench also disables a held entry through its configuration word, where a design that keeps stale ownership would still read the mutex set. Finally it sweeps every static-ID and query-ID pair on the allow outputs to catch a wrong wildcard or semaphore-mode precedence.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int CID_W   = 3;
  localparam int NUM_CID = 1 << CID_W;
  localparam logic [31:0] CFG_MASK = 32'h00FF_0073;

  typedef struct packed {
    logic [NUM_CID-1:0] wl;
    logic [CID_W-1:0]   scid;
    logic               semen;
    logic               cfen;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [31:0] d);
    cfg_t c;
    c.wl    = d[23:16];
    c.scid  = d[6:4];
    c.semen = d[1];
    c.cfen  = d[0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input cfg_t c);
    return {8'h00, c.wl, 9'h000, c.scid, 2'b00, c.semen, c.cfen};
  endfunction

  function automatic logic [31:0] sem_pack(input logic held, input logic [CID_W-1:0] own);
    return {25'h0, held ? own : {CID_W{1'b0}}, 3'b000, held};
  endfunction
endpackage

// File: rtl/sem_decode.sv
module sem_decode #(
  parameter int N_ENTRY = 8,
  parameter int ADDR_W  = 12,
  parameter int BASE    = 'h100,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              is_sem_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-3:0] slot;

  always_comb begin
    off      = addr_i - ADDR_W'(BASE);
    slot     = {1'b0, off[ADDR_W-1:3]};
    hit_o    = (addr_i >= ADDR_W'(BASE)) && (slot < (ADDR_W-2)'(N_ENTRY)) && (off[1:0] == 2'b00);
    is_sem_o = off[2];
    idx_o    = off[IDX_W+2:3];
  end
endmodule

// File: rtl/sem_entry.sv
module sem_entry
  import sem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             sem_we_i,
  input  logic [31:0]      wdata_i,
  input  logic [CID_W-1:0] cid_i,
  input  logic [CID_W-1:0] chk_cid_i,
  output cfg_t             cfg_o,
  output logic             held_o,
  output logic [CID_W-1:0] owner_o,
  output logic             allow_o
);
  cfg_t             cfg_q, cfg_d;
  logic             held_q, held_d;
  logic [CID_W-1:0] own_q, own_d;
  logic             sem_mode, sem_mode_d, hit1;

  assign sem_mode = cfg_q.cfen & cfg_q.semen;
  assign hit1     = sem_we_i & wdata_i[0] & sem_mode;

  always_comb begin
    cfg_d  = cfg_we_i ? cfg_unpack(wdata_i) : cfg_q;
    held_d = held_q;
    own_d  = own_q;
    if (hit1) begin
      if (!held_q && cfg_q.wl[cid_i]) begin
        held_d = 1'b1;
        own_d  = cid_i;
      end else if (held_q && own_q == cid_i) begin
        held_d = 1'b0;
      end
    end
    sem_mode_d = cfg_d.cfen & cfg_d.semen;
    if (!sem_mode_d) held_d = 1'b0;  // disabling the mode frees the lock
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      held_q <= 1'b0;
      own_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      held_q <= held_d;
      own_q  <= own_d;
    end
  end

  always_comb begin
    if (!cfg_q.cfen)   allow_o = 1'b1;
    else if (sem_mode) allow_o = held_q && (own_q == chk_cid_i);
    else               allow_o = (cfg_q.scid == '0) || (cfg_q.scid == chk_cid_i);
  end

  assign cfg_o   = cfg_q;
  assign held_o  = held_q;
  assign owner_o = own_q;

  p_acquire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit1 && !held_q && cfg_q.wl[cid_i]) |=> (held_q && own_q == $past(cid_i)));
  p_no_wl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_we_i && !held_q && !cfg_q.wl[cid_i]) |=> !held_q);
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit1 && held_q && own_q == cid_i) |=> !held_q);
  p_intruder_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_we_i && held_q && own_q != cid_i) |=> (held_q && $stable(own_q)));
  p_zero_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_we_i && !wdata_i[0]) |=> ($stable(held_q) && $stable(own_q)));
  p_forced_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q.cfen && cfg_q.semen) |-> !held_q);
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [CID_W-1:0]   cid_i,
  output logic [31:0]        rdata_o,
  input  logic [CID_W-1:0]   chk_cid_i,
  output logic [N_ENTRY-1:0] allow_o
);
  logic             hit, is_sem;
  logic [IDX_W-1:0] idx;
  cfg_t             cfg_a  [N_ENTRY];
  logic             held_a [N_ENTRY];
  logic [CID_W-1:0] own_a  [N_ENTRY];
  logic [31:0]      rd_word, rdata_q;

  sem_decode #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .hit_o(hit), .is_sem_o(is_sem), .idx_o(idx)
  );

  for (genvar n = 0; n < N_ENTRY; n++) begin : g_ent
    logic sel;
    assign sel = req_i && we_i && hit && (idx == IDX_W'(n));
    sem_entry u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cfg_we_i(sel && !is_sem), .sem_we_i(sel && is_sem),
      .wdata_i(wdata_i), .cid_i(cid_i), .chk_cid_i(chk_cid_i),
      .cfg_o(cfg_a[n]), .held_o(held_a[n]), .owner_o(own_a[n]), .allow_o(allow_o[n])
    );
  end

  always_comb begin
    rd_word = '0;
    if (hit) rd_word = is_sem ? sem_pack(held_a[idx], own_a[idx]) : cfg_pack(cfg_a[idx]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));
  p_cfg_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit && !is_sem) |=> ((rdata_o & ~CFG_MASK) == '0));
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int N = 8;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] cid = '0, chk = '0;
  logic [N-1:0] allow;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sem_bank #(.N_ENTRY(N), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .cid_i(cid), .rdata_o(rdata), .chk_cid_i(chk), .allow_o(allow)
  );

  function automatic logic [AW-1:0] cfg_a(int e); return AW'(32'h100 + 8*e); endfunction
  function automatic logic [AW-1:0] sem_a(int e); return AW'(32'h104 + 8*e); endfunction

  task automatic chk32(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [2:0] c);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; cid = c;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic rd_chk(string r, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk32(r, d, exp);
  endtask

  task automatic allow_chk(string r, int e, logic [2:0] q, logic exp);
    @(negedge clk); chk = q; #1;
    chk32(r, {31'b0, allow[e]}, {31'b0, exp});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] wl;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int e = 0; e < N; e++) begin
      rd_chk("R1", cfg_a(e), 32'h0);
      rd_chk("R1", sem_a(e), 32'h0);
    end
    // R2 field mask and layout
    for (int e = 0; e < N; e++) begin
      wr(cfg_a(e), 32'hFFFF_FFFF, 3'd0);
      rd_chk("R2", cfg_a(e), 32'h00FF_0073);
      wr(cfg_a(e), 32'h0000_0000, 3'd0);
      rd_chk("R2", cfg_a(e), 32'h0);
    end
    // R3..R7, R9 sweep of entries and compartments
    for (int e = 0; e < N; e++) begin
      wl = 8'((e * 37 + 5) & 8'hFF);
      wr(cfg_a(e), 32'h3 | (32'(wl) << 16) | 32'h50, 3'd0);
      for (int c = 0; c < 8; c++) begin
        int o;
        o = (c + 1) % 8;
        wr(sem_a(e), 32'h1, 3'(c));
        ok = wl[c];
        if (ok) begin
          rd_chk("R3", sem_a(e), 32'(c << 4) | 32'h1);
          allow_chk("R9", e, 3'(c), 1'b1);
          allow_chk("R9", e, 3'(o), 1'b0);
          wr(sem_a(e), 32'h1, 3'(o));
          rd_chk("R6", sem_a(e), 32'(c << 4) | 32'h1);
          wr(sem_a(e), 32'hFFFF_FFFE, 3'(c));
          rd_chk("R7", sem_a(e), 32'(c << 4) | 32'h1);
          wr(sem_a(e), 32'h1, 3'(c));
          rd_chk("R5", sem_a(e), 32'h0);
        end else begin
          rd_chk("R4", sem_a(e), 32'h0);
          allow_chk("R9", e, 3'(c), 1'b0);
        end
      end
    end
    // R8 forced free by clearing either enable
    for (int e = 0; e < N; e++) begin
      wr(cfg_a(e), 32'h00FF_0003, 3'd0);
      wr(sem_a(e), 32'h1, 3'(e));
      rd_chk("R3", sem_a(e), 32'((e % 8) << 4) | 32'h1);
      wr(cfg_a(e), (e % 2 == 0) ? 32'h00FF_0001 : 32'h00FF_0002, 3'd0);
      rd_chk("R8", sem_a(e), 32'h0);
      // R7 no semaphore mode: write ignored
      wr(sem_a(e), 32'h1, 3'(e));
      rd_chk("R7", sem_a(e), 32'h0);
    end
    // R9 static ID filter and filter-off
    for (int s = 0; s < 8; s++) begin
      wr(cfg_a(2), 32'h1 | 32'(s << 4), 3'd0);
      for (int q = 0; q < 8; q++) allow_chk("R9", 2, 3'(q), (s == 0) || (s == q));
    end
    wr(cfg_a(2), 32'h70, 3'd0);
    for (int q = 0; q < 8; q++) allow_chk("R9", 2, 3'(q), 1'b1);
    // R10 unmapped addresses
    wr(12'h000, 32'hFFFF_FFFF, 3'd0);
    rd_chk("R10", 12'h000, 32'h0);
    wr(cfg_a(N), 32'hFFFF_FFFF, 3'd0);
    rd_chk("R10", cfg_a(N), 32'h0);
    rd_chk("R10", AW'(32'h102), 32'h0);
    rd_chk("R10", cfg_a(0), 32'h00FF_0001);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule